// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block performs the integer arithmetic and logic work of a simple 32-bit processor datapath. A two-bit mode code from the main instruction decoder chooses the operation. The mode can force an address-style addition, force an equality-test subtraction, or hand the choice to the six-bit function field of a register-format instruction. Immediate-format instructions use the same function codes. The main decoder supplies the code of the matching register operation together with mode 10, and it places the sign- or zero-extended immediate on operand B.

Each cycle the unit takes the mode, function field and both operands at the rising clock edge. From these it registers three outputs: the 32-bit result, a zero flag that serves as the branch equality test, and a signed-overflow flag. The set-on-less-than operations return the literal value 1 or 0. Only the trapping add and subtract ever raise the overflow flag.

Top module: `alu_unit`

## Requirements
- R1: While rst_n is low, result_o, zero_o and ovf_o are all 0 at every rising edge.
- R2: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge, giving one cycle of latency.
- R3: Mode 00 (memory address) gives opa_i + opb_i modulo 2^32, and ovf_o stays 0 even when the signed sum wraps.
- R4: Mode 01 (branch compare) gives opa_i - opb_i modulo 2^32. zero_o is 1 exactly when the operands are equal, and ovf_o stays 0.
- R5: Under mode 10, function code 0x20 (add) and 0x21 (addu) both give the modulo-2^32 sum, and 0x22 (sub) and 0x23 (subu) both give the modulo-2^32 difference A - B.
- R6: Under mode 10, function code 0x24 gives bitwise AND, 0x25 gives OR, 0x26 gives XOR and 0x27 gives NOR of the operands.
- R7: Under mode 10, function code 0x2A gives 1 when A < B as two's complement numbers and 0 otherwise. Bits 31..1 of the result are always 0.
- R8: Under mode 10, function code 0x2B gives 1 when A < B as unsigned numbers and 0 otherwise. Bits 31..1 of the result are always 0.
- R9: ovf_o is 1 only for function codes 0x20 and 0x22 under mode 10, and then exactly when the signed result does not fit in 32 bits. For 0x21 and 0x23 it is always 0.
- R10: For every operation, zero_o is 1 exactly when all 32 result bits are 0.
- R11: Mode 11, or mode 10 with a function code not listed above, gives result 0, zero_o 1 and ovf_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_mode_i | input | 2 | Mode code from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| opa_i | input | 32 | Operand A (first source register) |
| opb_i | input | 32 | Operand B (second source register or extended immediate) |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag: result is all zeros |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The clocked properties assume that mode, function field and operands are settled at each rising edge and carry known values. Each property relates the outputs one cycle after an edge to the inputs $past sampled at that edge. The bench meets this assumption by changing inputs only on the falling edge and reading outputs on the next falling edge. It also holds the inputs at defined values throughout reset, so that no property reads an unknown operand in the first cycle after release.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNCT_W = 6;
    localparam int MODE_W  = 2;

    // Mode codes from the main decoder
    localparam logic [MODE_W-1:0] MODE_MEM   = 2'b00;
    localparam logic [MODE_W-1:0] MODE_BRANCH = 2'b01;
    localparam logic [MODE_W-1:0] MODE_FIELD = 2'b10;

    // Function field codes
    localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FUNCT_W-1:0] FN_AND  = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FUNCT_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FUNCT_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_ADDU,
        OP_SUB,
        OP_SUBU,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_SLT,
        OP_SLTU
    } alu_op_e;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import alu_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output alu_op_e            op_o
);

    alu_op_e field_op;

    always_comb begin
        unique case (funct_i)
            FN_ADD:  field_op = OP_ADD;
            FN_ADDU: field_op = OP_ADDU;
            FN_SUB:  field_op = OP_SUB;
            FN_SUBU: field_op = OP_SUBU;
            FN_AND:  field_op = OP_AND;
            FN_OR:   field_op = OP_OR;
            FN_XOR:  field_op = OP_XOR;
            FN_NOR:  field_op = OP_NOR;
            FN_SLT:  field_op = OP_SLT;
            FN_SLTU: field_op = OP_SLTU;
            default: field_op = OP_NONE;
        endcase
    end

    always_comb begin
        unique case (mode_i)
            MODE_MEM:    op_o = OP_ADDU;   // address add never flags overflow
            MODE_BRANCH: op_o = OP_SUBU;   // equality test never flags overflow
            MODE_FIELD:  op_o = field_op;
            default:     op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o,
    output logic              ovf_o
);

    localparam int MSB = DATA_W - 1;

    logic              sub_sel;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              wrap;
    logic              lt_signed;
    logic              lt_unsigned;

    // One shared adder serves add, subtract and both comparisons
    always_comb begin
        sub_sel = (op_i == OP_SUB) || (op_i == OP_SUBU) ||
                  (op_i == OP_SLT) || (op_i == OP_SLTU);
        b_eff   = sub_sel ? ~b_i : b_i;
        sum_ext = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_sel};
        sum     = sum_ext[DATA_W-1:0];
        carry   = sum_ext[DATA_W];
        wrap    = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
        lt_signed   = sum[MSB] ^ wrap;
        lt_unsigned = ~carry;
    end

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU: result_o = sum;
            OP_AND:          result_o = a_i & b_i;
            OP_OR:           result_o = a_i | b_i;
            OP_XOR:          result_o = a_i ^ b_i;
            OP_NOR:          result_o = ~(a_i | b_i);
            OP_SLT:          result_o = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_SLTU:         result_o = {{(DATA_W-1){1'b0}}, lt_unsigned};
            default:         result_o = '0;
        endcase
        zero_o = ~|result_o;
        ovf_o  = wrap && ((op_i == OP_ADD) || (op_i == OP_SUB));
    end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   alu_mode_i,
    input  logic [FUNCT_W-1:0]  funct_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                zero_o,
    output logic                ovf_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic              ovf;
    } out_t;

    alu_op_e           op;
    logic [DATA_W-1:0] core_result;
    logic              core_zero;
    logic              core_ovf;
    out_t              out_d;
    out_t              out_q;

    alu_fn_decode u_decode (
        .mode_i  (alu_mode_i),
        .funct_i (funct_i),
        .op_o    (op)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .op_i     (op),
        .result_o (core_result),
        .zero_o   (core_zero),
        .ovf_o    (core_ovf)
    );

    always_comb begin
        out_d.result = core_result;
        out_d.zero   = core_zero;
        out_d.ovf    = core_ovf;
        if (!rst_n) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign result_o = out_q.result;
    assign zero_o   = out_q.zero;
    assign ovf_o    = out_q.ovf;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MODE_W-1:0]   alu_mode_i,
    input logic [FUNCT_W-1:0]  funct_i,
    input logic [DATA_W-1:0]   opa_i,
    input logic [DATA_W-1:0]   opb_i,
    input logic [DATA_W-1:0]   result_o,
    input logic                zero_o,
    input logic                ovf_o
);

    assert_mem_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode_i == MODE_MEM) |=>
            (result_o == $past(opa_i) + $past(opb_i)) && !ovf_o);

    assert_branch_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode_i == MODE_BRANCH) |=>
            (zero_o == ($past(opa_i) == $past(opb_i))) && !ovf_o);

    assert_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode_i == MODE_FIELD && funct_i == FN_AND) |=>
            (result_o == ($past(opa_i) & $past(opb_i))));

    assert_slt_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode_i == MODE_FIELD && (funct_i == FN_SLT || funct_i == FN_SLTU)) |=>
            (result_o[DATA_W-1:1] == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_mode_i == MODE_FIELD && (funct_i == FN_ADD || funct_i == FN_SUB)) |=>
            !ovf_o);

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode_i == 2'b11) |=> (result_o == '0) && zero_o && !ovf_o);

endmodule

bind alu_unit alu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_mode_i (alu_mode_i),
    .funct_i    (funct_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .ovf_o      (ovf_o)
);

// File: tb/alu_unit_tb.sv
`timescale 1ns/1ps
module alu_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alu_mode_i = 2'b00;
    logic [5:0]  funct_i = 6'h00;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .alu_mode_i (alu_mode_i),
        .funct_i    (funct_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .result_o   (result_o),
        .zero_o     (zero_o),
        .ovf_o      (ovf_o)
    );

    task automatic check(string tag, logic [31:0] er, logic ez, logic eo);
        checks++;
        if (result_o !== er || zero_o !== ez || ovf_o !== eo) begin
            errors++;
            $display("FAIL %s: got result=%h zero=%b ovf=%b, expected result=%h zero=%b ovf=%b",
                     tag, result_o, zero_o, ovf_o, er, ez, eo);
        end
    endtask

    task automatic run(string tag, logic [1:0] m, logic [5:0] f, logic [31:0] a,
                       logic [31:0] b, logic [31:0] er, logic ez, logic eo);
        @(negedge clk);
        alu_mode_i = m; funct_i = f; opa_i = a; opb_i = b;
        @(negedge clk);
        check(tag, er, ez, eo);
    endtask

    task automatic t_reset();
        alu_mode_i = 2'b10; funct_i = 6'h25; opa_i = 32'hFFFF_0000; opb_i = 32'h0000_FFFF;
        repeat (3) @(negedge clk);
        check("R1 outputs cleared in reset", 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        alu_mode_i = 2'b00; funct_i = 6'h00; opa_i = '0; opb_i = '0;
    endtask

    task automatic t_latency();
        run("R2 first vector", 2'b00, 6'h00, 32'd10, 32'd20, 32'd30, 1'b0, 1'b0);
        @(negedge clk);
        alu_mode_i = 2'b00; opa_i = 32'd100; opb_i = 32'd1;
        #1;
        check("R2 output held until edge", 32'd30, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 new value after edge", 32'd101, 1'b0, 1'b0);
    endtask

    task automatic t_mem();
        run("R3 base plus negative offset", 2'b00, 6'h2A, 32'h0000_1000, 32'hFFFF_FFFC,
            32'h0000_0FFC, 1'b0, 1'b0);
        run("R3 wrap without overflow", 2'b00, 6'h20, 32'h7FFF_FFFF, 32'h1,
            32'h8000_0000, 1'b0, 1'b0);
    endtask

    task automatic t_branch();
        run("R4 equal operands", 2'b01, 6'h00, 32'h1234_5678, 32'h1234_5678, 32'h0, 1'b1, 1'b0);
        run("R4 unequal operands", 2'b01, 6'h00, 32'd5, 32'd3, 32'd2, 1'b0, 1'b0);
        run("R4 signed wrap no overflow", 2'b01, 6'h22, 32'h8000_0000, 32'h1,
            32'h7FFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_arith();
        run("R5 add", 2'b10, 6'h20, 32'd3, 32'd4, 32'd7, 1'b0, 1'b0);
        run("R5 addu carry out R10", 2'b10, 6'h21, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b0);
        run("R5 sub", 2'b10, 6'h22, 32'd10, 32'd3, 32'd7, 1'b0, 1'b0);
        run("R5 subu borrow", 2'b10, 6'h23, 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run("R5 add mixed signs", 2'b10, 6'h20, 32'd5, 32'hFFFF_FFFD, 32'd2, 1'b0, 1'b0);
    endtask

    task automatic t_logic();
        run("R6 and", 2'b10, 6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0);
        run("R6 or",  2'b10, 6'h25, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0);
        run("R6 xor", 2'b10, 6'h26, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFF00_0FF0, 1'b0, 1'b0);
        run("R6 nor", 2'b10, 6'h27, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h000F_F000, 1'b0, 1'b0);
        run("R6 and disjoint R10", 2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_slt();
        run("R7 minus one below one", 2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b0, 1'b0);
        run("R7 one not below minus one", 2'b10, 6'h2A, 32'h1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
        run("R7 equal", 2'b10, 6'h2A, 32'd9, 32'd9, 32'h0, 1'b1, 1'b0);
        run("R7 most negative below most positive", 2'b10, 6'h2A, 32'h8000_0000,
            32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0);
    endtask

    task automatic t_sltu();
        run("R8 max not below one", 2'b10, 6'h2B, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b0);
        run("R8 one below max", 2'b10, 6'h2B, 32'h1, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
        run("R8 equal", 2'b10, 6'h2B, 32'd2, 32'd2, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_overflow();
        run("R9 add positive overflow", 2'b10, 6'h20, 32'h7FFF_FFFF, 32'h1,
            32'h8000_0000, 1'b0, 1'b1);
        run("R9 add negative overflow R10", 2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000,
            32'h0, 1'b1, 1'b1);
        run("R9 sub overflow low", 2'b10, 6'h22, 32'h8000_0000, 32'h1,
            32'h7FFF_FFFF, 1'b0, 1'b1);
        run("R9 sub overflow high", 2'b10, 6'h22, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
            32'h8000_0000, 1'b0, 1'b1);
        run("R9 addu never flags", 2'b10, 6'h21, 32'h7FFF_FFFF, 32'h1,
            32'h8000_0000, 1'b0, 1'b0);
        run("R9 subu never flags", 2'b10, 6'h23, 32'h8000_0000, 32'h1,
            32'h7FFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_undefined();
        run("R11 unlisted funct 0x00", 2'b10, 6'h00, 32'h1234_5678, 32'h1, 32'h0, 1'b1, 1'b0);
        run("R11 unlisted funct 0x28", 2'b10, 6'h28, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            32'h0, 1'b1, 1'b0);
        run("R11 mode 11", 2'b11, 6'h20, 32'h7FFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_mem();
        t_branch();
        t_arith();
        t_logic();
        t_slt();
        t_sltu();
        t_overflow();
        t_undefined();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule